// File: doc/BRIEF.md
# Output Post-Divider with Power-Down Ramp

This block produces the synthesizer's output clock from the fast VCO clock. A 2-bit select picks a post-division of 1, 2, 4 or 8. Every output period is built from two half-periods of equal length, so the duty cycle stays at 50% at every ratio. To allow this, the divider always includes a fixed factor of two. The output period is therefore 2^(n_sel+1) VCO cycles. The division ratio is sampled only at a rising edge of the output clock, so the period in progress always finishes at its old length.

The power-down input does not stop the clock. While it is held, an extra division grows by one factor of two on each rising edge of a slow reference clock. The steps run 1, 2, 4, 8 and then 16. When power-down is released, the frequency comes back in four halving steps paced in the same way. If the request flips partway through a ramp, the ramp turns around from the level it has reached. Power-down and the reference clock each pass through a two-flop synchronizer into the VCO domain. Reference edges are detected there, so all state runs on the single VCO clock. `ramp_busy` shows that the extra division has not yet reached the value the synchronized request calls for.

Top module: `pdiv_out_ramp`

## Requirements
- R1: With power-down low and no ramp pending, `n_sel` = 0, 1, 2, 3 gives an output period of 2, 4, 8, 16 `vco_clk` cycles.
- R2: In every output period, the high half and the low half last the same number of `vco_clk` cycles.
- R3: Once a power-down ramp has finished, the output period is 2^(n_sel+5) `vco_clk` cycles. This is sixteen times the R1 value.
- R4: The extra division moves by exactly one factor of two per step. A step occurs only after a synchronized rising edge of `ref_clk`, and at most one step is taken per such edge.
- R5: After power-down is released from full depth with `n_sel` = 0, the output periods pass through 32, 16, 8, 4 and 2 cycles, with no value skipped.
- R6: After power-down is asserted with `n_sel` = 0, the output periods pass through 2, 4, 8, 16 and 32 cycles, with no value skipped.
- R7: A change of `n_sel` takes effect at the next output rising edge. The period in progress completes at the old ratio.
- R8: `ramp_busy` is high while the extra division differs from its target: 16 when the synchronized power-down is high, 1 when it is low. It is low otherwise. Every level step occurs while `ramp_busy` is high.
- R9: If power-down is released partway through a ramp, the extra division turns back from its current level without reaching 16, and returns to 1. The level rises only while the synchronized request is high, and falls only while it is low.
- R10: During reset and right after it, `clk_out` is low, `ramp_busy` is low and the extra division is 1, whatever the state of power-down before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast VCO clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock that paces the ramp steps; sampled through a synchronizer |
| n_sel | input | NSEL_W (2) | Post-division select: 0 gives ÷1, 1 gives ÷2, 2 gives ÷4, 3 gives ÷8; quasi-static, sampled at output rising edges |
| pwr_dn | input | 1 | Power-down request, asynchronous level |
| clk_out | output | 1 | Divided output clock with 50% duty cycle |
| ramp_busy | output | 1 | High while a ramp has steps still to take |

## Verification
A ramp step can fall partway through an output period, and the division ratio is latched only at the output rising edge. A level change and a boundary latch can therefore land in the same cycle, or one period apart. The reference clock runs unrelated to the output, so every ramp test produces both alignments. Each completed period is judged by two checks: its halves must be equal, and the sequence of period lengths must change by exactly one factor of two. A second overlap is a direction reversal that arrives while a step is pending. It is provoked by releasing power-down as soon as the ×4 period appears, and it is judged by the peak and final period lengths.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // Direction of the next ramp step.
  typedef enum logic [1:0] {
    RS_HOLD    = 2'd0,
    RS_DEEPEN  = 2'd1,
    RS_RESTORE = 2'd2
  } ramp_move_e;

  // Choose the move from the request and the level bounds.
  function automatic ramp_move_e pick_move(input logic pd_req,
                                           input logic at_floor,
                                           input logic at_ceil);
    ramp_move_e m;
    if (pd_req && !at_ceil)        m = RS_DEEPEN;
    else if (!pd_req && !at_floor) m = RS_RESTORE;
    else                           m = RS_HOLD;
    return m;
  endfunction

endpackage

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pdiv_ramp.sv
module pdiv_ramp
  import pdiv_pkg::*;
#(
  parameter int RAMP_STEPS = 4,
  parameter int LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_s,
  input  logic             pd_s,
  output logic [LVL_W-1:0] level,
  output logic             busy
);

  localparam logic [LVL_W-1:0] CEIL = LVL_W'(RAMP_STEPS);

  logic       ref_q;
  logic       ref_tick;
  logic       at_floor, at_ceil;
  ramp_move_e move;

  // A step is allowed only on a synchronized reference rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_s;
  end

  assign ref_tick = ref_s & ~ref_q;
  assign at_floor = (level == '0);
  assign at_ceil  = (level == CEIL);

  always_comb move = pick_move(pd_s, at_floor, at_ceil);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (ref_tick) begin
      unique case (move)
        RS_DEEPEN:  level <= level + 1'b1;
        RS_RESTORE: level <= level - 1'b1;
        default:    level <= level;
      endcase
    end
  end

  assign busy = (move != RS_HOLD);

endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
  parameter int NSEL_W = 2,
  parameter int LVL_W  = 3,
  parameter int EXP_W  = 3,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEL_W-1:0] n_sel,
  input  logic [LVL_W-1:0]  level,
  output logic              clk_out
);

  logic [EXP_W-1:0] e_next;
  logic [EXP_W-1:0] e_cur;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   half_m1;
  logic             half_end;
  logic             clk_q;

  // Total exponent: programmed ratio plus the ramp's extra division.
  assign e_next  = EXP_W'(n_sel) + EXP_W'(level);
  assign half_m1 = ((CNT_W+1)'(1) << e_cur) - (CNT_W+1)'(1);
  assign half_end = ({1'b0, cnt} == half_m1);

  // Both halves use the same e_cur; it is reloaded only as the output rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_q <= 1'b0;
      e_cur <= '0;
    end else if (half_end) begin
      cnt   <= '0;
      clk_q <= ~clk_q;
      if (!clk_q) e_cur <= e_next;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign clk_out = clk_q;

endmodule

// File: rtl/pdiv_out_ramp.sv
module pdiv_out_ramp #(
  parameter int NSEL_W      = 2,
  parameter int RAMP_STEPS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              vco_clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic [NSEL_W-1:0] n_sel,
  input  logic              pwr_dn,
  output logic              clk_out,
  output logic              ramp_busy
);

  localparam int LVL_W = $clog2(RAMP_STEPS + 1);
  localparam int EMAX  = (1 << NSEL_W) - 1 + RAMP_STEPS;
  localparam int EXP_W = $clog2(EMAX + 1);
  localparam int CNT_W = (EMAX < 1) ? 1 : EMAX;

  logic [1:0]       sync_q;
  logic             ref_s;
  logic             pd_s;
  logic [LVL_W-1:0] lvl;

  pdiv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (vco_clk),
    .rst_n (rst_n),
    .d     ({ref_clk, pwr_dn}),
    .q     (sync_q)
  );

  assign ref_s = sync_q[1];
  assign pd_s  = sync_q[0];

  pdiv_ramp #(.RAMP_STEPS(RAMP_STEPS), .LVL_W(LVL_W)) u_ramp (
    .clk   (vco_clk),
    .rst_n (rst_n),
    .ref_s (ref_s),
    .pd_s  (pd_s),
    .level (lvl),
    .busy  (ramp_busy)
  );

  pdiv_core #(.NSEL_W(NSEL_W), .LVL_W(LVL_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_core (
    .clk     (vco_clk),
    .rst_n   (rst_n),
    .n_sel   (n_sel),
    .level   (lvl),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/pdiv_out_ramp_chk.sv
module pdiv_out_ramp_chk #(
  parameter int RAMP_STEPS = 4,
  parameter int LVL_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] lvl,
  input logic             ref_s,
  input logic             pd_s,
  input logic             ramp_busy
);

  p_level_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(RAMP_STEPS));

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> (lvl == $past(lvl) + 1'b1) || (lvl + 1'b1 == $past(lvl)));

  p_step_on_ref_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> ($past(ref_s) && !$past(ref_s, 2)));

  p_step_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> $past(ramp_busy));

  p_deepen_needs_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl > $past(lvl)) |-> $past(pd_s));

  p_restore_needs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl < $past(lvl)) |-> !$past(pd_s));

endmodule

bind pdiv_out_ramp pdiv_out_ramp_chk #(
  .RAMP_STEPS(RAMP_STEPS),
  .LVL_W     (LVL_W)
) u_chk (
  .clk       (vco_clk),
  .rst_n     (rst_n),
  .lvl       (lvl),
  .ref_s     (ref_s),
  .pd_s      (pd_s),
  .ramp_busy (ramp_busy)
);

// File: tb/test_pdiv_out_ramp.sv
`timescale 1ns/1ps
module test_pdiv_out_ramp;

  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic [1:0] n_sel;
  logic       pwr_dn;
  logic       clk_out;
  logic       ramp_busy;

  int n_chk  = 0;
  int n_fail = 0;

  // Monitor state: period measurement sampled at the falling edge.
  int  hi_c = 0, lo_c = 0;
  bit  prev_o = 1'b0;
  int  rise_cnt = 0;
  int  last_period = 0;
  int  last_hi = 0;
  int  bad_duty = 0;
  bit  hist_en = 1'b0;
  int  hist_n = 0;
  int  hist [512];

  // {n_sel, pwr_dn, expected period}
  localparam logic [11:0] VEC [0:7] = '{
    {2'd0, 1'b0, 9'd2},
    {2'd1, 1'b0, 9'd4},
    {2'd2, 1'b0, 9'd8},
    {2'd3, 1'b0, 9'd16},
    {2'd3, 1'b1, 9'd256},
    {2'd1, 1'b1, 9'd64},
    {2'd0, 1'b1, 9'd32},
    {2'd2, 1'b0, 9'd8}
  };

  pdiv_out_ramp i_pdiv_out_ramp (
    .vco_clk   (vco_clk),
    .rst_n     (rst_n),
    .ref_clk   (ref_clk),
    .n_sel     (n_sel),
    .pwr_dn    (pwr_dn),
    .clk_out   (clk_out),
    .ramp_busy (ramp_busy)
  );

  always #10   vco_clk = ~vco_clk;
  always #1000 ref_clk = ~ref_clk;

  always @(negedge vco_clk) begin
    if (!rst_n) begin
      hi_c = 0; lo_c = 0; prev_o = 1'b0;
    end else begin
      if (clk_out && !prev_o) begin
        if (hi_c != 0) begin
          last_period = hi_c + lo_c;
          last_hi     = hi_c;
          if (hi_c != lo_c) bad_duty++;
          if (hist_en && hist_n < 512) begin
            hist[hist_n] = hi_c + lo_c;
            hist_n++;
          end
        end
        rise_cnt++;
        hi_c = 1; lo_c = 0;
      end else if (clk_out) begin
        hi_c++;
      end else begin
        lo_c++;
      end
      prev_o = clk_out;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_rises(input int k);
    repeat (k) begin
      int r = rise_cnt;
      wait (rise_cnt != r);
    end
    #1;
  endtask

  task automatic cycles(input int k);
    repeat (k) @(negedge vco_clk);
    #2;
  endtask

  task automatic settle();
    cycles(8);
    wait (!ramp_busy);
    wait_rises(4);
  endtask

  task automatic start_hist();
    hist_n  = 0;
    hist_en = 1'b1;
  endtask

  // Distinct-period walk over the history.
  task automatic analyze(output int nd, output int first, output int last,
                         output int maxv, output int bad_steps);
    int prev = -1;
    nd = 0; first = 0; last = 0; maxv = 0; bad_steps = 0;
    for (int i = 0; i < hist_n; i++) begin
      if (hist[i] != prev) begin
        if (prev >= 0 && hist[i] != prev * 2 && prev != hist[i] * 2) bad_steps++;
        if (nd == 0) first = hist[i];
        nd++;
        prev = hist[i];
      end
      if (hist[i] > maxv) maxv = hist[i];
    end
    last = prev;
  endtask

  initial begin
    int nd, first, last, maxv, bad;
    rst_n = 1'b0; n_sel = 2'd0; pwr_dn = 1'b0;
    cycles(5);
    chk(clk_out == 1'b0,   "R10", "clk_out in reset", clk_out, 0);
    chk(ramp_busy == 1'b0, "R10", "busy in reset", ramp_busy, 0);
    rst_n = 1'b1;

    // Table walk: steady ratios with and without power-down (R1, R2, R3).
    for (int i = 0; i < 8; i++) begin
      logic [11:0] v = VEC[i];
      n_sel  = v[11:10];
      pwr_dn = v[9];
      settle();
      chk(last_period == int'(v[8:0]), v[9] ? "R3" : "R1", "period",
          last_period, int'(v[8:0]));
      chk(last_hi * 2 == int'(v[8:0]), "R2", "high half", last_hi, int'(v[8:0]) / 2);
    end

    // Ramp down with n_sel = 0 (R6, R4, R8).
    n_sel = 2'd0;
    settle();
    start_hist();
    pwr_dn = 1'b1;
    cycles(4);
    chk(ramp_busy == 1'b1, "R8", "busy after request", ramp_busy, 1);
    wait (!ramp_busy);
    wait_rises(4);
    hist_en = 1'b0;
    analyze(nd, first, last, maxv, bad);
    chk(nd == 5,     "R6", "distinct periods down", nd, 5);
    chk(first == 2,  "R6", "first period down", first, 2);
    chk(last == 32,  "R6", "last period down", last, 32);
    chk(bad == 0,    "R4", "non-halving steps down", bad, 0);

    // Ramp up from full depth (R5, R4, R8).
    start_hist();
    pwr_dn = 1'b0;
    cycles(4);
    chk(ramp_busy == 1'b1, "R8", "busy after release", ramp_busy, 1);
    wait (!ramp_busy);
    wait_rises(4);
    hist_en = 1'b0;
    analyze(nd, first, last, maxv, bad);
    chk(nd == 5,     "R5", "distinct periods up", nd, 5);
    chk(first == 32, "R5", "first period up", first, 32);
    chk(last == 2,   "R5", "last period up", last, 2);
    chk(bad == 0,    "R4", "non-halving steps up", bad, 0);
    cycles(300);
    chk(ramp_busy == 1'b0, "R8", "busy after ramp done", ramp_busy, 0);

    // Reversal partway down (R9, R4).
    start_hist();
    pwr_dn = 1'b1;
    wait (last_period == 8);
    cycles(1);
    pwr_dn = 1'b0;
    cycles(4);
    wait (!ramp_busy);
    wait_rises(4);
    hist_en = 1'b0;
    analyze(nd, first, last, maxv, bad);
    chk(maxv < 32,  "R9", "peak period on reversal", maxv, 16);
    chk(last == 2,  "R9", "period after reversal", last, 2);
    chk(bad == 0,   "R4", "non-halving steps on reversal", bad, 0);

    // Ratio change partway through a period (R7).
    n_sel = 2'd3;
    settle();
    wait_rises(1);
    start_hist();
    cycles(3);
    n_sel = 2'd0;
    wait_rises(3);
    hist_en = 1'b0;
    chk(hist_n >= 2 && hist[0] == 16, "R7", "period holding old ratio", hist[0], 16);
    chk(hist_n >= 2 && hist[1] == 2,  "R7", "period at new ratio", hist[1], 2);

    // Reset at full depth clears the ramp (R10).
    n_sel  = 2'd1;
    pwr_dn = 1'b1;
    settle();
    rst_n  = 1'b0;
    cycles(3);
    chk(clk_out == 1'b0, "R10", "clk_out in second reset", clk_out, 0);
    pwr_dn = 1'b0;
    rst_n  = 1'b1;
    cycles(5);
    chk(ramp_busy == 1'b0, "R10", "busy after reset", ramp_busy, 0);
    wait_rises(3);
    chk(last_period == 4, "R10", "period right after reset", last_period, 4);

    chk(bad_duty == 0, "R2", "periods with unequal halves", bad_duty, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge vco_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 190000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule